// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block steps a clock generator into and out of its low-power state. The power-down request is active low and arrives with no timing relation to the internal clock. Once synchronized, it starts a fixed shutdown order. First the fast output clocks (CPU and PCI groups) are held low, with the hold changing on a falling clock edge so no output pulse is cut short. Next the slower reference and 48 MHz outputs are held low. Then the VCO enable drops, and the crystal-oscillator enable drops last.

Wake-up runs the same steps in reverse. The oscillator is enabled and given a settle interval. Then the VCO is enabled and given its own settle interval. Only after both intervals are the output holds released. Every interval is a cycle-count parameter; the oscillator settle count stands in for the 4 ms power-up limit. A shutdown that has started always completes before wake-up begins. A wake-up that has started always reaches the running state before a new shutdown begins.

Two asynchronous clock-stop requests are also synchronized here, for the CPU group and the PCI group. While the generator runs, each drives a low-hold gate that changes on a falling edge. Outside the running state both gates freeze, and the requests have no effect on the sequence.

Top module: `clkgen_pd_sequencer`

## Requirements
- R1: While reset is asserted and after it is released with pd_n high: core_hold_low, slow_hold_low, cpu_gate_low and pci_gate_low are 0, and vco_en and osc_en are 1.
- R2: Number the first rising edge that samples pd_n low as edge 1. The sequencer leaves the running state at edge SYNC_STAGES+1. core_hold_low goes to 1 at the falling edge that follows that edge.
- R3: slow_hold_low goes to 1 SLOW_DELAY cycles after the running state is left (1 <= SLOW_DELAY < HOLD_CYCLES).
- R4: vco_en goes to 0 HOLD_CYCLES cycles after the running state is left. Whenever vco_en or osc_en is 0, both output holds are 1.
- R5: osc_en goes to 0 VCO_GAP cycles after vco_en goes to 0.
- R6: If pd_n returns high before shutdown has finished, the whole shutdown still runs. The oscillator-off state lasts at least one cycle.
- R7: Let a release edge be a rising edge at least SYNC_STAGES+1 edges after pd_n is sampled high. Wake-up starts at the first edge that is both a release edge and one cycle or more after osc_en fell; osc_en goes to 1 at that edge. vco_en goes to 1 XTAL_SETTLE cycles later. Both holds go to 0 VCO_SETTLE cycles after that.
- R8: If pd_n is asserted again during wake-up, wake-up still completes. The running state then lasts at least one cycle before the next shutdown starts, with the same timing as R2.
- R9: While running, cpu_gate_low follows the inverse of cpu_stop_n, and pci_gate_low follows the inverse of pci_stop_n. Each gate changes at the falling edge after rising edge SYNC_STAGES+1, counted as in R2.
- R10: Once the running state is left, both gates keep their last value until the sequencer is running again. Changes on cpu_stop_n or pci_stop_n during that time do not alter any sequence timing.
- R11: vco_en is never 1 while osc_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | Asynchronous CPU-group stop request, active low |
| pci_stop_n | input | 1 | Asynchronous PCI-group stop request, active low |
| core_hold_low | output | 1 | Holds CPU and PCI outputs low; changes on a falling edge |
| slow_hold_low | output | 1 | Holds reference and 48 MHz outputs low |
| cpu_gate_low | output | 1 | CPU-group stop gate; changes on a falling edge |
| pci_gate_low | output | 1 | PCI-group stop gate; changes on a falling edge |
| vco_en | output | 1 | VCO enable |
| osc_en | output | 1 | Crystal-oscillator enable |

## Verification
Two functions can fall in the same cycle. A power-down request and a clock-stop change can reach the sequencer on the same edge. Separately, a pd_n release can arrive while shutdown is still running, and a new request can arrive while wake-up is running. The bench sweeps the release point across every shutdown cycle and the re-request point across every wake-up cycle. It also sweeps the stop-input change across the edges around the shutdown entry. For each window it computes from the parameters the expected enables, holds and frozen gate values, and compares all six outputs.

// File: rtl/clkgen_pd_pkg.sv
`timescale 1ns/1ps
package clkgen_pd_pkg;

   typedef enum logic [2:0] {
      PD_RUN       = 3'd0,
      PD_STOP_OUT  = 3'd1,
      PD_VCO_OFF   = 3'd2,
      PD_XTAL_OFF  = 3'd3,
      PD_WAKE_XTAL = 3'd4,
      PD_WAKE_VCO  = 3'd5
   } pd_state_e;

   typedef struct packed {
      logic core_hold;
      logic slow_hold;
      logic vco_en;
      logic osc_en;
   } pd_ctrl_t;

   localparam pd_ctrl_t PD_CTRL_RESET = '{core_hold: 1'b0, slow_hold: 1'b0,
                                          vco_en: 1'b1, osc_en: 1'b1};

   function automatic int unsigned max4(int unsigned a, int unsigned b,
                                        int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/clkgen_pd_sync.sv
`timescale 1ns/1ps
module clkgen_pd_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkgen_pd_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/clkgen_pd_retime.sv
`timescale 1ns/1ps
module clkgen_pd_retime #(
   parameter int unsigned WIDTH    = 1,
   parameter bit          NEG_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (NEG_EDGE) begin : g_falling
         logic [WIDTH-1:0] hold_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) hold_q <= '0;
            else        hold_q <= d;
         end
         assign q = hold_q;
      end else begin : g_direct
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/clkgen_pd_fsm.sv
`timescale 1ns/1ps
module clkgen_pd_fsm
   import clkgen_pd_pkg::*;
#(
   parameter int unsigned SLOW_DELAY  = 2,
   parameter int unsigned HOLD_CYCLES = 4,
   parameter int unsigned VCO_GAP     = 3,
   parameter int unsigned XTAL_SETTLE = 10,
   parameter int unsigned VCO_SETTLE  = 6
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     sleep_req,
   output pd_ctrl_t ctrl_q,
   output logic     running
);

   localparam int unsigned CNT_MAX = max4(HOLD_CYCLES, VCO_GAP, XTAL_SETTLE, VCO_SETTLE);
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);
   localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(VCO_GAP - 1);
   localparam logic [CNT_W-1:0] XS_LAST   = CNT_W'(XTAL_SETTLE - 1);
   localparam logic [CNT_W-1:0] VS_LAST   = CNT_W'(VCO_SETTLE - 1);
   localparam logic [CNT_W-1:0] SLOW_AT   = CNT_W'(SLOW_DELAY);

   pd_state_e        state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   pd_ctrl_t         ctrl_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q + 1'b1;
      unique case (state_q)
         PD_RUN: begin
            cnt_d = '0;
            if (sleep_req) state_d = PD_STOP_OUT;
         end
         PD_STOP_OUT: begin
            if (cnt_q == HOLD_LAST) begin
               state_d = PD_VCO_OFF;
               cnt_d   = '0;
            end
         end
         PD_VCO_OFF: begin
            if (cnt_q == GAP_LAST) begin
               state_d = PD_XTAL_OFF;
               cnt_d   = '0;
            end
         end
         PD_XTAL_OFF: begin
            cnt_d = '0;
            if (!sleep_req) state_d = PD_WAKE_XTAL;
         end
         PD_WAKE_XTAL: begin
            if (cnt_q == XS_LAST) begin
               state_d = PD_WAKE_VCO;
               cnt_d   = '0;
            end
         end
         PD_WAKE_VCO: begin
            if (cnt_q == VS_LAST) begin
               state_d = PD_RUN;
               cnt_d   = '0;
            end
         end
         default: begin
            state_d = PD_RUN;
            cnt_d   = '0;
         end
      endcase
   end

   always_comb begin
      ctrl_d.core_hold = (state_d != PD_RUN);
      ctrl_d.slow_hold = (state_d == PD_STOP_OUT) ? (cnt_d >= SLOW_AT)
                                                   : (state_d != PD_RUN);
      ctrl_d.vco_en    = (state_d == PD_RUN) || (state_d == PD_STOP_OUT) ||
                         (state_d == PD_WAKE_VCO);
      ctrl_d.osc_en    = (state_d != PD_XTAL_OFF);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PD_RUN;
         cnt_q   <= '0;
         ctrl_q  <= PD_CTRL_RESET;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         ctrl_q  <= ctrl_d;
      end
   end

   assign running = (state_q == PD_RUN);

endmodule

// File: rtl/clkgen_pd_sequencer.sv
`timescale 1ns/1ps
module clkgen_pd_sequencer
   import clkgen_pd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SLOW_DELAY  = 2,
   parameter int unsigned HOLD_CYCLES = 4,
   parameter int unsigned VCO_GAP     = 3,
   parameter int unsigned XTAL_SETTLE = 10,
   parameter int unsigned VCO_SETTLE  = 6,
   parameter bit          NEG_RETIME  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_n,
   input  logic cpu_stop_n,
   input  logic pci_stop_n,
   output logic core_hold_low,
   output logic slow_hold_low,
   output logic cpu_gate_low,
   output logic pci_gate_low,
   output logic vco_en,
   output logic osc_en
);

   localparam int unsigned N_ASYNC = 3;
   localparam int unsigned N_GATE  = 2;
   localparam int unsigned N_RET   = N_GATE + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("clkgen_pd_sequencer: SYNC_STAGES must be at least 2");
      end
      if (SLOW_DELAY < 1 || SLOW_DELAY >= HOLD_CYCLES) begin : g_bad_slow
         $error("clkgen_pd_sequencer: need 1 <= SLOW_DELAY < HOLD_CYCLES");
      end
      if (VCO_GAP < 1 || XTAL_SETTLE < 1 || VCO_SETTLE < 1) begin : g_bad_intervals
         $error("clkgen_pd_sequencer: intervals must be at least 1 cycle");
      end
   endgenerate

   logic [N_ASYNC-1:0] async_in, sync_out;
   pd_ctrl_t           ctrl;
   logic               running;
   logic [N_GATE-1:0]  gate_q;
   logic [N_RET-1:0]   ret_in, ret_out;

   assign async_in = {pci_stop_n, cpu_stop_n, pd_n};

   clkgen_pd_sync #(
      .WIDTH   (N_ASYNC),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({N_ASYNC{1'b1}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (async_in),
      .q     (sync_out)
   );

   clkgen_pd_fsm #(
      .SLOW_DELAY  (SLOW_DELAY),
      .HOLD_CYCLES (HOLD_CYCLES),
      .VCO_GAP     (VCO_GAP),
      .XTAL_SETTLE (XTAL_SETTLE),
      .VCO_SETTLE  (VCO_SETTLE)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (~sync_out[0]),
      .ctrl_q    (ctrl),
      .running   (running)
   );

   // stop gates track their requests only while running, frozen otherwise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gate_q <= '0;
      else if (running) gate_q <= ~sync_out[N_ASYNC-1:1];
   end

   assign ret_in = {gate_q, ctrl.core_hold};

   clkgen_pd_retime #(
      .WIDTH    (N_RET),
      .NEG_EDGE (NEG_RETIME)
   ) u_retime (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ret_in),
      .q     (ret_out)
   );

   assign core_hold_low = ret_out[0];
   assign cpu_gate_low  = ret_out[1];
   assign pci_gate_low  = ret_out[2];
   assign slow_hold_low = ctrl.slow_hold;
   assign vco_en        = ctrl.vco_en;
   assign osc_en        = ctrl.osc_en;

endmodule

// File: rtl/clkgen_pd_checker.sv
`timescale 1ns/1ps
module clkgen_pd_checker (
   input logic clk,
   input logic rst_n,
   input logic core_hold_low,
   input logic slow_hold_low,
   input logic cpu_gate_low,
   input logic pci_gate_low,
   input logic vco_en,
   input logic osc_en
);

   assert_vco_needs_osc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      vco_en |-> osc_en);

   assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!vco_en || !osc_en) |-> (core_hold_low && slow_hold_low));

   assert_osc_after_vco_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_en) |-> !vco_en);

   assert_vco_after_osc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vco_en) |-> (osc_en && $past(osc_en)));

   assert_release_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(slow_hold_low) |-> (vco_en && osc_en));

   assert_gates_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_hold_low && $past(slow_hold_low)) |->
         ($stable(cpu_gate_low) && $stable(pci_gate_low)));

endmodule

bind clkgen_pd_sequencer clkgen_pd_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .core_hold_low (core_hold_low),
   .slow_hold_low (slow_hold_low),
   .cpu_gate_low  (cpu_gate_low),
   .pci_gate_low  (pci_gate_low),
   .vco_en        (vco_en),
   .osc_en        (osc_en)
);

// File: tb/test_clkgen_pd_sequencer.sv
`timescale 1ns/1ps
module test_clkgen_pd_sequencer;

   localparam int S   = 2;
   localparam int SD  = 2;
   localparam int H   = 4;
   localparam int G   = 3;
   localparam int XS  = 10;
   localparam int VS  = 6;
   localparam int BIG = 1 << 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pd_n = 1'b1;
   logic cpu_stop_n = 1'b1;
   logic pci_stop_n = 1'b1;
   logic core_hold_low, slow_hold_low, cpu_gate_low, pci_gate_low, vco_en, osc_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   clkgen_pd_sequencer #(
      .SYNC_STAGES (S), .SLOW_DELAY (SD), .HOLD_CYCLES (H), .VCO_GAP (G),
      .XTAL_SETTLE (XS), .VCO_SETTLE (VS), .NEG_RETIME (1'b1)
   ) i_clkgen_pd_sequencer (
      .clk (clk), .rst_n (rst_n), .pd_n (pd_n),
      .cpu_stop_n (cpu_stop_n), .pci_stop_n (pci_stop_n),
      .core_hold_low (core_hold_low), .slow_hold_low (slow_hold_low),
      .cpu_gate_low (cpu_gate_low), .pci_gate_low (pci_gate_low),
      .vco_en (vco_en), .osc_en (osc_en)
   );

   task automatic check(input logic act, input logic exp, input string req, input int win);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s window %0d: actual %b expected %b", req, win, act, exp);
      end
   endtask

   function automatic bit run_after(int e, int t0, int r, int t1);
      return (e < t0) || (e >= r && e < t1);
   endfunction

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   task automatic do_reset(input bit cpu0, input bit pci0);
      @(posedge clk); #2;
      rst_n = 1'b0; pd_n = 1'b1; cpu_stop_n = cpu0; pci_stop_n = pci0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      repeat (S + 4) @(posedge clk);
   endtask

   // window j: sampled 6 ns after rising edge j; inputs change 2 ns after edge j
   task automatic run_case(input string tag, input bit do_pd, input int r, input int q,
                           input bit cpu0, input bit cpu1, input bit pci0, input bit pci1,
                           input int d);
      int t0, x, w, v, rr, t1, len;
      do_reset(cpu0, pci0);
      t0 = do_pd ? S + 1 : BIG;
      x  = t0 + H + G;
      w  = do_pd ? imax(x + 1, r + S + 1) : BIG;
      v  = w + XS;
      rr = v + VS;
      t1 = (q > 0) ? imax(rr + 1, q + S + 1) : BIG;
      len = (q > 0) ? t1 + H + G + 3 : (do_pd ? rr + 4 : 20);
      for (int j = 0; j <= len; j++) begin
         int u;
         bit src_cpu, src_pci;
         bit e_core, e_slow, e_vco, e_osc;
         @(posedge clk); #2;
         if (do_pd && j == 0) pd_n = 1'b0;
         if (do_pd && j == r) pd_n = 1'b1;
         if (q > 0 && j == q) pd_n = 1'b0;
         if (j == d) begin cpu_stop_n = cpu1; pci_stop_n = pci1; end
         #4;
         e_core = !run_after(j, t0, rr, t1);
         e_slow = (j >= t0 + SD && j < rr) || (j >= t1 + SD);
         e_vco  = !((j >= t0 + H && j < v) || (j >= t1 + H));
         e_osc  = !((j >= x && j < w) || (j >= t1 + H + G));
         u = j;
         while (!run_after(u - 1, t0, rr, t1)) u--;
         src_cpu = (u - S - 1 >= d) ? cpu1 : cpu0;
         src_pci = (u - S - 1 >= d) ? pci1 : pci0;
         check(core_hold_low, e_core, {tag, " R2 core_hold_low"}, j);
         check(slow_hold_low, e_slow, {tag, " R3 slow_hold_low"}, j);
         check(vco_en,        e_vco,  {tag, " R4 vco_en"}, j);
         check(osc_en,        e_osc,  {tag, " R5 osc_en"}, j);
         check(cpu_gate_low,  !src_cpu, {tag, " R9/R10 cpu_gate_low"}, j);
         check(pci_gate_low,  !src_pci, {tag, " R9/R10 pci_gate_low"}, j);
      end
   endtask

   initial begin
      int x0;
      x0 = S + 1 + H + G;
      // R1: reset values, during and after reset
      #10;
      check(core_hold_low, 1'b0, "R1 core_hold_low in reset", 0);
      check(slow_hold_low, 1'b0, "R1 slow_hold_low in reset", 0);
      check(vco_en, 1'b1, "R1 vco_en in reset", 0);
      check(osc_en, 1'b1, "R1 osc_en in reset", 0);
      check(cpu_gate_low, 1'b0, "R1 cpu_gate_low in reset", 0);
      check(pci_gate_low, 1'b0, "R1 pci_gate_low in reset", 0);
      do_reset(1'b1, 1'b1);
      #6;
      check(core_hold_low, 1'b0, "R1 core_hold_low after reset", 0);
      check(vco_en, 1'b1, "R1 vco_en after reset", 0);
      check(osc_en, 1'b1, "R1 osc_en after reset", 0);
      // R6 and R7: release point swept through shutdown and beyond
      for (int r = 1; r <= x0 + 4; r++)
         run_case("R6/R7 release sweep", 1'b1, r, 0, 1'b1, 1'b1, 1'b1, 1'b1, BIG);
      // R9: stop requests while running
      run_case("R9 cpu stop", 1'b0, 0, 0, 1'b1, 1'b0, 1'b1, 1'b1, 2);
      run_case("R9 pci stop", 1'b0, 0, 0, 1'b0, 1'b1, 1'b1, 1'b0, 3);
      // R10: stop change around and after shutdown entry
      for (int d = 0; d <= S + 4; d++)
         run_case("R10 stop during sleep", 1'b1, x0 + 2, 0, 1'b1, 1'b0, 1'b0, 1'b1, d);
      // R8: new request placed throughout wake-up
      for (int q = x0 + 2; q <= x0 + 2 + S + XS + VS + 2; q++)
         run_case("R8 request in wake", 1'b1, x0, q, 1'b1, 1'b1, 1'b1, 1'b1, BIG);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule